// File: doc/BRIEF.md
# Serial Command Frame Decoder for Multi-Channel Stimulation Parameters

This block sits behind a four-wire serial slave port (clock, active-low select, data in, data out). It receives fixed 40-bit command frames and brings them into the system clock domain. A frame is acted on only if it is exactly 40 bits long and its trailing 8-bit sum matches the 32 payload bits. A verified write updates one 16-bit parameter register in one channel, or in every channel when the broadcast bit is set. The same write also loads the stimulation-enable bit of each affected channel and the shared timebase selection. For each write the block emits a one-cycle strobe, a register index and the data word, so that per-channel pulse logic can follow the update.

A verified read selects one register. Its value is shifted out MSB first on the data-out line during the first 16 clocks of the next frame. Reads of channels that do not exist return zero. Every frame that is rejected, and every frame that is not a verified read, leaves zero queued for the next frame. The number of channels is a parameter. The channel address field is 6 bits wide, and any address at or above the channel count is reserved.

Top module: `spi_cmd_decoder`

## Requirements
- R1: The payload is the first 32 bits received, MSB first. It is laid out, from the top bit down, as: write flag (1 = write, 0 = read), broadcast flag, stim-enable flag, timebase select (2 bits), 2 spare bits, channel address (6), register index (3) and data (16). The last 8 bits must equal the sum modulo 256 of the four payload bytes. On a mismatch no register, output or queued read value changes, except that the queued read value becomes zero.
- R2: A frame is committed when the select line rises, and only if exactly 40 serial clock rising edges were seen while it was low. A shorter or longer frame is discarded.
- R3: A verified write to an address below NCH stores the data in that channel's register at the given index. It pulses only that channel's bit of wr_stb_o for one cycle, with wr_idx_o and wr_data_o holding the index and the data.
- R4: A verified write with the broadcast flag set writes the index in every channel and pulses all bits of wr_stb_o, whatever the address field holds.
- R5: A verified write without broadcast to an address at or above NCH changes no register, no strobe, no stim enable and no timebase select.
- R6: A verified read loads the addressed register, or zero for an address at or above NCH. This value appears on miso_o MSB first, valid before each of the first 16 serial clock rising edges of the following frame. A read changes no register.
- R7: A verified write sets stim_en_o of each channel it reaches to the stim-enable flag. Other channels keep their value.
- R8: A verified write that reaches at least one channel copies the timebase select field to clk_sel_o.
- R9: The 2 spare payload bits have no effect beyond their part in the checksum.
- R10: After reset, all registers, wr_stb_o, stim_en_o, clk_sel_o and miso_o are zero.
- R11: After any committed or discarded frame that is not a verified read, miso_o returns zeros during the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock, data sampled on rising edge |
| cs_ni | input | 1 | Frame select, active low |
| mosi_i | input | 1 | Serial data in |
| miso_o | output | 1 | Serial data out, read results |
| wr_stb_o | output | NCH | One-cycle write strobe per channel |
| wr_idx_o | output | 3 | Register index of the last write |
| wr_data_o | output | 16 | Data of the last write |
| stim_en_o | output | NCH | Stimulation enable per channel |
| clk_sel_o | output | 2 | Timebase selection |

## Verification
The bench builds the block with NCH = 4, so 60 of the 64 address codes are reserved. A sweep can then write and read back every address code and confirm that exactly four of them land. With only four channels, every channel can be read back after broadcast and stim-enable updates, so any stray write or missed channel shows up at miso_o. Frames of 39 and 41 bits, corrupted sums and frames with the spare bits set are each run against registers whose contents are known.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int FRAME_W = 40;
  localparam int DATA_W  = 16;
  localparam int NREG    = 8;
  localparam int ADDR_W  = 6;

  typedef struct packed {
    logic              wr;
    logic              glob;
    logic              stim;
    logic [1:0]        tsel;
    logic [1:0]        spare;
    logic [ADDR_W-1:0] addr;
    logic [2:0]        idx;
    logic [DATA_W-1:0] data;
  } payload_t;

  function automatic logic [7:0] frame_sum(input logic [31:0] p);
    return p[31:24] + p[23:16] + p[15:8] + p[7:0];
  endfunction
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end
  assign q_o = s2_q;
endmodule

// File: rtl/spi_frame_rx.sv
module spi_frame_rx
  import spi_cmd_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sclk_s_i,
  input  logic               cs_s_i,
  input  logic               mosi_s_i,
  output logic               done_o,
  output logic               len_ok_o,
  output logic [FRAME_W-1:0] frame_o,
  output logic               sclk_fall_o
);
  localparam int CNT_W = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(FRAME_W + 1);
  localparam logic [CNT_W-1:0] CNT_OK  = CNT_W'(FRAME_W);

  logic               sclk_q, cs_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [FRAME_W-1:0] sh_q;
  logic               sclk_rise, cs_fall, cs_rise;

  assign sclk_rise   = sclk_s_i & ~sclk_q & ~cs_s_i;
  assign sclk_fall_o = ~sclk_s_i & sclk_q & ~cs_s_i;
  assign cs_fall     = ~cs_s_i & cs_q;
  assign cs_rise     = cs_s_i & ~cs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q   <= 1'b0;
      cs_q     <= 1'b1;
      cnt_q    <= '0;
      sh_q     <= '0;
      done_o   <= 1'b0;
      len_ok_o <= 1'b0;
      frame_o  <= '0;
    end else begin
      sclk_q <= sclk_s_i;
      cs_q   <= cs_s_i;
      done_o <= cs_rise;
      if (cs_rise) begin
        len_ok_o <= (cnt_q == CNT_OK);
        frame_o  <= sh_q;
      end
      if (cs_fall) cnt_q <= '0;
      else if (sclk_rise) begin
        sh_q <= {sh_q[FRAME_W-2:0], mosi_s_i};
        if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/param_bank.sv
module param_bank
  import spi_cmd_pkg::*;
#(
  parameter int NCH  = 32,
  parameter int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NCH-1:0]    we_i,
  input  logic [2:0]        idx_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [CH_W-1:0]   rd_ch_i,
  input  logic [2:0]        rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] mem [NCH][NREG];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int r = 0; r < NREG; r++) mem[c][r] <= '0;
      end else if (we_i[c]) begin
        mem[c][idx_i] <= data_i;
      end
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int c = 0; c < NCH; c++)
      if (rd_ch_i == CH_W'(c)) rd_data_o = mem[c][rd_idx_i];
  end
endmodule

// File: rtl/spi_cmd_decoder.sv
module spi_cmd_decoder
  import spi_cmd_pkg::*;
#(
  parameter int NCH = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              cs_ni,
  input  logic              mosi_i,
  output logic              miso_o,
  output logic [NCH-1:0]    wr_stb_o,
  output logic [2:0]        wr_idx_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic [NCH-1:0]    stim_en_o,
  output logic [1:0]        clk_sel_o
);
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;

  logic               sclk_s, cs_s, mosi_s;
  logic               done_w, len_ok_w, ck_ok_w, sclk_fall_w;
  logic [FRAME_W-1:0] frame_w;
  payload_t           pl;
  logic               good, addr_ok;
  logic [NCH-1:0]     hit;
  logic [DATA_W-1:0]  rd_data;
  logic [DATA_W-1:0]  tx_q;
  logic               unused_spare;

  spi_sync #(.W(3), .RST_VAL(3'b010)) u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .d_i   ({sclk_i, cs_ni, mosi_i}),
    .q_o   ({sclk_s, cs_s, mosi_s})
  );

  spi_frame_rx u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sclk_s_i   (sclk_s),
    .cs_s_i     (cs_s),
    .mosi_s_i   (mosi_s),
    .done_o     (done_w),
    .len_ok_o   (len_ok_w),
    .frame_o    (frame_w),
    .sclk_fall_o(sclk_fall_w)
  );

  assign pl           = payload_t'(frame_w[FRAME_W-1:8]);
  assign unused_spare = ^pl.spare;
  assign ck_ok_w      = (frame_sum(frame_w[FRAME_W-1:8]) == frame_w[7:0]);
  assign good         = done_w & len_ok_w & ck_ok_w;
  assign addr_ok      = (32'(pl.addr) < 32'(NCH));

  always_comb begin
    hit = '0;
    if (good && pl.wr) begin
      if (pl.glob) hit = '1;
      else if (addr_ok) hit[pl.addr[CH_W-1:0]] = 1'b1;
    end
  end

  param_bank #(.NCH(NCH), .CH_W(CH_W)) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (hit),
    .idx_i    (pl.idx),
    .data_i   (pl.data),
    .rd_ch_i  (pl.addr[CH_W-1:0]),
    .rd_idx_i (pl.idx),
    .rd_data_o(rd_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_stb_o  <= '0;
      wr_idx_o  <= '0;
      wr_data_o <= '0;
      stim_en_o <= '0;
      clk_sel_o <= '0;
      tx_q      <= '0;
    end else begin
      wr_stb_o <= hit;
      if (|hit) begin
        wr_idx_o  <= pl.idx;
        wr_data_o <= pl.data;
        clk_sel_o <= pl.tsel;
      end
      for (int c = 0; c < NCH; c++)
        if (hit[c]) stim_en_o[c] <= pl.stim;
      // read result queued for the next frame; anything else queues zero
      if (done_w)           tx_q <= (good && !pl.wr && addr_ok) ? rd_data : '0;
      else if (sclk_fall_w) tx_q <= {tx_q[DATA_W-2:0], 1'b0};
    end
  end

  assign miso_o = tx_q[DATA_W-1];
endmodule

// File: rtl/spi_cmd_decoder_chk.sv
module spi_cmd_decoder_chk #(
  parameter int NCH = 32
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [NCH-1:0] wr_stb_o,
  input logic [NCH-1:0] stim_en_o,
  input logic [1:0]     clk_sel_o,
  input logic           done_w,
  input logic           len_ok_w,
  input logic           ck_ok_w
);
  assert_stb_shape_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|wr_stb_o) |-> ($onehot(wr_stb_o) || (&wr_stb_o)));

  assert_stb_len_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|wr_stb_o) |-> $past(done_w && len_ok_w));

  assert_stb_sum_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|wr_stb_o) |-> $past(ck_ok_w));

  assert_stim_on_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(stim_en_o) |-> (|wr_stb_o));

  assert_tsel_on_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(clk_sel_o) |-> (|wr_stb_o));
endmodule

bind spi_cmd_decoder spi_cmd_decoder_chk #(.NCH(NCH)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_stb_o (wr_stb_o),
  .stim_en_o(stim_en_o),
  .clk_sel_o(clk_sel_o),
  .done_w   (done_w),
  .len_ok_w (len_ok_w),
  .ck_ok_w  (ck_ok_w)
);

// File: tb/test_spi_cmd_decoder.sv
module test_spi_cmd_decoder;
  localparam int NCH = 4;
  localparam int HP  = 6;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso;
  logic [NCH-1:0] wr_stb, stim_en;
  logic [2:0] wr_idx;
  logic [15:0] wr_data;
  logic [1:0] clk_sel;

  int checks = 0, errors = 0;
  int stb_cnt [NCH];
  logic [15:0] rx;

  always #10 clk = ~clk;

  spi_cmd_decoder #(.NCH(NCH)) i_spi_cmd_decoder (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .cs_ni(cs_n), .mosi_i(mosi),
    .miso_o(miso), .wr_stb_o(wr_stb), .wr_idx_o(wr_idx), .wr_data_o(wr_data),
    .stim_en_o(stim_en), .clk_sel_o(clk_sel)
  );

  always @(posedge clk) if (rst_ni) for (int c = 0; c < NCH; c++) if (wr_stb[c]) stb_cnt[c]++;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [39:0] mk(input logic wr, gl, st, input logic [1:0] ts, sp,
                                     input logic [5:0] a, input logic [2:0] ix, input logic [15:0] d);
    logic [31:0] p = {wr, gl, st, ts, sp, a, ix, d};
    logic [7:0] s = 8'((p[31:24] + p[23:16] + p[15:8] + p[7:0]) % 256);
    return {p, s};
  endfunction

  task automatic xfer(input logic [39:0] f, input int n, output logic [15:0] got);
    got = '0;
    @(negedge clk); cs_n = 1'b0;
    repeat (HP) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      mosi = (i < 40) ? f[39-i] : 1'b0;
      repeat (HP) @(negedge clk);
      if (i < 16) got[15-i] = miso;
      sclk = 1'b1;
      repeat (HP) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (HP) @(negedge clk);
    cs_n = 1'b1;
    repeat (3*HP) @(negedge clk);
  endtask

  // read back ch/idx: issue read, then a filler frame that shifts the result out
  task automatic rd(input logic [5:0] a, input logic [2:0] ix, output logic [15:0] v);
    logic [15:0] dummy;
    xfer(mk(1'b0, 1'b0, 1'b0, 2'd0, 2'd0, a, ix, 16'h0), 40, dummy);
    xfer(mk(1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 6'd63, 3'd0, 16'h0), 40, v);
  endtask

  function automatic logic [15:0] pat(input int a);
    return 16'hA000 ^ 16'(a * 16'h0123) ^ 16'(a % 8);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    for (int c = 0; c < NCH; c++) stb_cnt[c] = 0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 stim", 32'(stim_en), 0);
    check("R10 tsel", 32'(clk_sel), 0);
    check("R10 stb", 32'(wr_stb), 0);
    check("R10 miso", 32'(miso), 0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    rd(6'd1, 3'd3, v);
    check("R10 reg zero", 32'(v), 0);

    // R3/R5: write every address code, index = addr % 8
    for (int a = 0; a < 64; a++)
      xfer(mk(1'b1, 1'b0, 1'b0, 2'd0, 2'd0, 6'(a), 3'(a % 8), pat(a)), 40, v);
    check("R11 miso after write", 32'(v), 0);
    for (int c = 0; c < NCH; c++) check("R3/R5 strobe count", 32'(stb_cnt[c]), 1);
    check("R3 last wr_idx", 32'(wr_idx), 32'(3));
    check("R3 last wr_data", 32'(wr_data), 32'(pat(3)));
    check("R8 tsel unchanged by reserved", 32'(clk_sel), 0);
    // R6: sweep reads of every address code
    for (int a = 0; a < 64; a++) begin
      rd(6'(a), 3'(a % 8), v);
      check(a < NCH ? "R3 readback" : "R6/R5 reserved reads zero", 32'(v), a < NCH ? 32'(pat(a)) : 0);
    end
    for (int c = 0; c < NCH; c++) check("R6 reads do not write", 32'(stb_cnt[c]), 1);

    // R1: corrupted sum
    begin
      logic [39:0] f = mk(1'b1, 1'b0, 1'b1, 2'd3, 2'd0, 6'd1, 3'd1, 16'hDEAD);
      f[0] = ~f[0];
      xfer(f, 40, v);
      rd(6'd1, 3'd1, v);
      check("R1 bad sum ignored", 32'(v), 32'(pat(1)));
      check("R1 bad sum stim", 32'(stim_en), 0);
      check("R1 bad sum tsel", 32'(clk_sel), 0);
    end
    // R2: 39 and 41 bit frames
    xfer(mk(1'b1, 1'b0, 1'b1, 2'd1, 2'd0, 6'd2, 3'd2, 16'h1111), 39, v);
    xfer(mk(1'b1, 1'b0, 1'b1, 2'd1, 2'd0, 6'd2, 3'd2, 16'h2222), 41, v);
    rd(6'd2, 3'd2, v);
    check("R2 wrong length ignored", 32'(v), 32'(pat(2)));
    check("R2 wrong length stim", 32'(stim_en), 0);
    // R11: short read frame queues zero
    xfer(mk(1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 6'd2, 3'd2, 16'h0), 39, v);
    xfer(mk(1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 6'd63, 3'd0, 16'h0), 40, v);
    check("R11 discarded read gives zero", 32'(v), 0);

    // R4/R7/R8: broadcast with reserved address
    xfer(mk(1'b1, 1'b1, 1'b1, 2'd2, 2'd0, 6'd50, 3'd6, 16'h5A5A), 40, v);
    check("R7 broadcast stim", 32'(stim_en), 32'hF);
    check("R8 tsel", 32'(clk_sel), 2);
    for (int c = 0; c < NCH; c++) begin
      rd(6'(c), 3'd6, v);
      check("R4 broadcast readback", 32'(v), 32'h5A5A);
    end
    // R7: one channel disabled
    xfer(mk(1'b1, 1'b0, 1'b0, 2'd1, 2'd0, 6'd2, 3'd7, 16'h0777), 40, v);
    check("R7 per-channel stim", 32'(stim_en), 32'hB);
    check("R8 tsel per-channel", 32'(clk_sel), 1);
    // R9: spare bits set
    xfer(mk(1'b1, 1'b0, 1'b1, 2'd3, 2'd3, 6'd3, 3'd5, 16'hC3C3), 40, v);
    rd(6'd3, 3'd5, v);
    check("R9 spare bits ignored", 32'(v), 32'hC3C3);
    check("R9 tsel", 32'(clk_sel), 3);
    // R5: reserved write leaves stim and tsel
    xfer(mk(1'b1, 1'b0, 1'b0, 2'd0, 2'd0, 6'd4, 3'd5, 16'h0), 40, v);
    check("R5 stim kept", 32'(stim_en), 32'hB);
    check("R5 tsel kept", 32'(clk_sel), 3);
    // R6: all indices of channel 0
    for (int ix = 0; ix < 8; ix++) begin
      rd(6'd0, 3'(ix), v);
      check("R6 index sweep", 32'(v), ix == 6 ? 32'h5A5A : (ix == 0 ? 32'(pat(0)) : 0));
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule